// File: doc/BRIEF.md
# Two-Level Interrupt Status Scanner

This block gathers interrupt lines from a set of peripheral channels, each channel owning a small group of lines. A line that pulses high sets a sticky pending bit for its channel. A channel that has any pending bit, and whose enable is on, shows up in a summary vector. The summary vector is read in 32-channel words.

A scanner walks the summary words. It starts at the word holding the lowest registered channel and stops at the word holding the highest one. Inside each word it visits channels from the lowest bit up. For each channel it visits, it takes the channel's pending byte and presents one event per set bit, again lowest bit first. Each event leaves through a valid/ready handshake.

An event carries a packed identifier: the peripheral id that was stored when the channel was registered, the line index and the channel number. Software-side logic acknowledges an event by writing a one-hot mask to the clear port of that channel. Pending bits that are still set are presented again on the next pass.

Top module: `irq_scan_top`

## Requirements
- R1: After reset no event is valid, the lower channel bound reads 255, the upper bound reads 0, every pending bit is clear and every channel enable is off.
- R2: A registration of channel c lowers the lower bound to c if c is below it and raises the upper bound to c if c is above it. It also stores the 12-bit peripheral id for c.
- R3: The scan visits summary words from lowerBound/32 through upperBound/32 inclusive. While lowerBound/32 exceeds upperBound/32, no event is produced.
- R4: Word indices ascend during a pass. Inside a word, channels are taken lowest bit first, with channel = 32*word + bit. Inside a channel, pending lines are taken lowest index first.
- R5: The event identifier has bits [31:28] zero, the peripheral id in [27:16], the line index (0 to 7) in [15:8] and the channel number in [7:0].
- R6: A high level on line j of channel c sets pending bit j of c. The bit stays set until it is cleared. After a pass ends, a new pass starts from the first word while any enabled channel is pending, so uncleared bits are presented again.
- R7: Clear is write-one-to-clear: a clear of channel c with mask m drops the pending bits of c where m is 1. A line that is high in the same cycle as a clear of its bit leaves the bit set.
- R8: A channel whose enable is off is skipped even while it has pending bits. A mask command turns the enable off only if it is on, and an unmask turns it on only if it is off. Once unmasked, the channel's pending bits are presented.
- R9: While an event is valid and ready is low, the event stays valid with an unchanged identifier unless a clear or a registration arrives in that cycle.
- R10: A pending bit cleared after the scanner captured the channel is not presented. The scanner moves on to the channel's next remaining bit, or to the next channel if none is left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| irqIn | input | NUM_CH*LINES | Interrupt lines, channel c at bits [c*LINES +: LINES] |
| clrEn | input | 1 | Clear strobe |
| clrCh | input | 8 | Channel to clear |
| clrMask | input | LINES | One bits select the pending bits to clear |
| enCmdValid | input | 1 | Enable command strobe |
| enCmdCh | input | 8 | Channel for the enable command |
| enCmdOn | input | 1 | 1 = unmask, 0 = mask |
| regEn | input | 1 | Registration strobe |
| regCh | input | 8 | Channel being registered |
| regPpid | input | 12 | Peripheral id stored for the channel |
| evtReady | input | 1 | Consumer accepts the event |
| evtValid | output | 1 | Event present |
| evtId | output | 32 | Packed event identifier |
| minCh | output | 8 | Lower channel bound |
| maxCh | output | 8 | Upper channel bound |

## Verification
The assertions check the following on every cycle:
- the reset values of the bounds and of the valid output;
- that the bounds only widen on a registration;
- that a stalled event stays put;
- that the reserved identifier bits are zero;
- that every presented channel lies inside the current word window.

Only the bench scenarios can show the rest: the full service order across words, channels and lines; the repeated passes over uncleared bits; the masking and unmasking of a pending channel; the retraction of an event whose bit was cleared while it waited; and the same-cycle race between a set and a clear.

// File: rtl/irq_scan_pkg.sv
package irq_scan_pkg;
  localparam int ID_W = 32;

  // strobes from control into the datapath
  typedef struct packed {
    logic startScan;
    logic loadWord;
    logic nextWord;
    logic pickCh;
    logic loadStat;
    logic popBit;
  } scanCtrl_t;

  // conditions reported back to control
  typedef struct packed {
    logic anyPending;
    logic rangeOk;
    logic wordEmpty;
    logic lastWord;
    logic liveEmpty;
    logic liveLast;
  } scanFlag_t;

  typedef enum logic [2:0] {
    S_IDLE, S_LOADW, S_PICK, S_LOADS, S_EMIT
  } scanState_t;
endpackage

// File: rtl/irq_scan_dp.sv
module irq_scan_dp
  import irq_scan_pkg::*;
#(
  parameter int NUM_CH    = 64,
  parameter int LINES     = 8,
  parameter int WORD_BITS = 32,
  parameter int CH_W      = 8,
  parameter int PPID_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH*LINES-1:0] irqIn,
  input  logic                    clrEn,
  input  logic [CH_W-1:0]         clrCh,
  input  logic [LINES-1:0]        clrMask,
  input  logic                    enCmdValid,
  input  logic [CH_W-1:0]         enCmdCh,
  input  logic                    enCmdOn,
  input  logic                    regEn,
  input  logic [CH_W-1:0]         regCh,
  input  logic [PPID_W-1:0]       regPpid,
  input  scanCtrl_t               ctrl,
  output scanFlag_t               flags,
  output logic [ID_W-1:0]         evtId,
  output logic [CH_W-1:0]         minCh,
  output logic [CH_W-1:0]         maxCh
);
  localparam int NUM_WORDS = NUM_CH / WORD_BITS;
  localparam int BIT_W     = $clog2(WORD_BITS);
  localparam int WI_W      = CH_W - BIT_W;
  localparam int CHI_W     = $clog2(NUM_CH);
  localparam int LINE_W    = $clog2(LINES);
  localparam int PAD_W     = ID_W - PPID_W - 16;
  localparam logic [CH_W:0] NUM_CH_L = NUM_CH;

  logic [NUM_CH-1:0][LINES-1:0]  status;
  logic [NUM_CH-1:0]             enBits;
  logic [NUM_CH-1:0][PPID_W-1:0] ppidTab;
  logic [NUM_CH-1:0]             summary;

  logic [WI_W-1:0]      wordIdx;
  logic [WORD_BITS-1:0] wordCopy;
  logic [CH_W-1:0]      chSel;
  logic [LINES-1:0]     statCopy;

  logic [WORD_BITS-1:0] wordSel;
  logic [BIT_W-1:0]     lowBitW;
  logic [LINE_W-1:0]    lowBitS;
  logic [LINES-1:0]     liveBits;
  logic [LINES-1:0]     statusSel;
  logic [PPID_W-1:0]    ppidSel;
  logic [WI_W-1:0]      firstWord;
  logic [WI_W-1:0]      endWord;

  // per-channel pending, enable and id storage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status  <= '0;
      enBits  <= '0;
      ppidTab <= '0;
      minCh   <= '1;
      maxCh   <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        status[c] <= (status[c] & ~((clrEn && clrCh == CH_W'(c)) ? clrMask : '0))
                     | irqIn[c*LINES +: LINES];
        if (enCmdValid && enCmdCh == CH_W'(c)) begin
          if (enCmdOn && !enBits[c])
            enBits[c] <= 1'b1;
          else if (!enCmdOn && enBits[c])
            enBits[c] <= 1'b0;
        end
        if (regEn && regCh == CH_W'(c))
          ppidTab[c] <= regPpid;
      end
      if (regEn && {1'b0, regCh} < NUM_CH_L) begin
        if (regCh < minCh) minCh <= regCh;
        if (regCh > maxCh) maxCh <= regCh;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NUM_CH; c++)
      summary[c] = enBits[c] & (|status[c]);
  end

  assign firstWord = minCh[CH_W-1:BIT_W];
  assign endWord   = maxCh[CH_W-1:BIT_W];
  assign statusSel = status[chSel[CHI_W-1:0]];
  assign ppidSel   = ppidTab[chSel[CHI_W-1:0]];
  assign liveBits  = statCopy & statusSel;

  always_comb begin
    wordSel = '0;
    for (int w = 0; w < NUM_WORDS; w++)
      if (wordIdx == WI_W'(w)) wordSel = summary[w*WORD_BITS +: WORD_BITS];
  end

  always_comb begin
    lowBitW = '0;
    for (int b = WORD_BITS - 1; b >= 0; b--)
      if (wordCopy[b]) lowBitW = BIT_W'(b);
  end

  always_comb begin
    lowBitS = '0;
    for (int b = LINES - 1; b >= 0; b--)
      if (liveBits[b]) lowBitS = LINE_W'(b);
  end

  // working copies of the scan
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordIdx  <= '0;
      wordCopy <= '0;
      chSel    <= '0;
      statCopy <= '0;
    end else begin
      if (ctrl.startScan) wordIdx <= firstWord;
      if (ctrl.nextWord)  wordIdx <= wordIdx + 1'b1;
      if (ctrl.loadWord)  wordCopy <= wordSel;
      if (ctrl.pickCh) begin
        chSel             <= {wordIdx, lowBitW};
        wordCopy[lowBitW] <= 1'b0;
      end
      if (ctrl.loadStat) statCopy <= statusSel;
      if (ctrl.popBit)   statCopy[lowBitS] <= 1'b0;
    end
  end

  assign flags.anyPending = |summary;
  assign flags.rangeOk    = firstWord <= endWord;
  assign flags.wordEmpty  = wordCopy == '0;
  assign flags.lastWord   = wordIdx == endWord;
  assign flags.liveEmpty  = liveBits == '0;
  assign flags.liveLast   = (liveBits & (liveBits - 1'b1)) == '0;

  assign evtId = {{PAD_W{1'b0}}, ppidSel, {(8-LINE_W){1'b0}}, lowBitS, chSel};
endmodule

// File: rtl/irq_scan_ctrl.sv
module irq_scan_ctrl
  import irq_scan_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  scanFlag_t flags,
  input  logic      evtReady,
  output scanCtrl_t ctrl,
  output logic      evtValid
);
  scanState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    evtValid  = 1'b0;
    case (state)
      S_IDLE: if (flags.anyPending && flags.rangeOk) begin
        ctrl.startScan = 1'b1;
        stateNext      = S_LOADW;
      end
      S_LOADW: begin
        ctrl.loadWord = 1'b1;
        stateNext     = S_PICK;
      end
      S_PICK: begin
        if (!flags.wordEmpty) begin
          ctrl.pickCh = 1'b1;
          stateNext   = S_LOADS;
        end else if (flags.lastWord) begin
          stateNext = S_IDLE;
        end else begin
          ctrl.nextWord = 1'b1;
          stateNext     = S_LOADW;
        end
      end
      S_LOADS: begin
        ctrl.loadStat = 1'b1;
        stateNext     = S_EMIT;
      end
      S_EMIT: begin
        evtValid = !flags.liveEmpty;
        if (flags.liveEmpty) begin
          stateNext = S_PICK;
        end else if (evtReady) begin
          ctrl.popBit = 1'b1;
          if (flags.liveLast) stateNext = S_PICK;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end
endmodule

// File: rtl/irq_scan_top.sv
module irq_scan_top
  import irq_scan_pkg::*;
#(
  parameter int NUM_CH    = 64,
  parameter int LINES     = 8,
  parameter int WORD_BITS = 32,
  parameter int CH_W      = 8,
  parameter int PPID_W    = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_CH*LINES-1:0] irqIn,
  input  logic                    clrEn,
  input  logic [CH_W-1:0]         clrCh,
  input  logic [LINES-1:0]        clrMask,
  input  logic                    enCmdValid,
  input  logic [CH_W-1:0]         enCmdCh,
  input  logic                    enCmdOn,
  input  logic                    regEn,
  input  logic [CH_W-1:0]         regCh,
  input  logic [PPID_W-1:0]       regPpid,
  input  logic                    evtReady,
  output logic                    evtValid,
  output logic [ID_W-1:0]         evtId,
  output logic [CH_W-1:0]         minCh,
  output logic [CH_W-1:0]         maxCh
);
  scanCtrl_t ctrl;
  scanFlag_t flags;

  irq_scan_dp #(
    .NUM_CH(NUM_CH), .LINES(LINES), .WORD_BITS(WORD_BITS),
    .CH_W(CH_W), .PPID_W(PPID_W)
  ) i_dp (
    .clk(clk), .rstN(rstN), .irqIn(irqIn),
    .clrEn(clrEn), .clrCh(clrCh), .clrMask(clrMask),
    .enCmdValid(enCmdValid), .enCmdCh(enCmdCh), .enCmdOn(enCmdOn),
    .regEn(regEn), .regCh(regCh), .regPpid(regPpid),
    .ctrl(ctrl), .flags(flags), .evtId(evtId),
    .minCh(minCh), .maxCh(maxCh)
  );

  irq_scan_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .flags(flags), .evtReady(evtReady),
    .ctrl(ctrl), .evtValid(evtValid)
  );
endmodule

// File: rtl/irq_scan_checker.sv
module irq_scan_checker #(
  parameter int CH_W = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            evtValid,
  input logic            evtReady,
  input logic [31:0]     evtId,
  input logic [CH_W-1:0] minCh,
  input logic [CH_W-1:0] maxCh,
  input logic            regEn,
  input logic [CH_W-1:0] regCh,
  input logic            clrEn
);
  p_reset_state_r1: assert property (@(posedge clk)
    !rstN |=> (!evtValid && minCh == '1 && maxCh == '0));

  p_bounds_cover_r2: assert property (@(posedge clk) disable iff (!rstN)
    regEn |=> (minCh <= $past(regCh) && maxCh >= $past(regCh)));

  p_bounds_widen_r2: assert property (@(posedge clk) disable iff (!rstN)
    !regEn |=> ($stable(minCh) && $stable(maxCh)));

  p_in_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtId[7:5] >= minCh[CH_W-1:5] && evtId[7:5] <= maxCh[CH_W-1:5]));

  p_id_fields_r5: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtId[31:28] == 4'h0 && evtId[15:11] == 5'h0));

  p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady && !clrEn && !regEn) |=> (evtValid && $stable(evtId)));
endmodule

bind irq_scan_top irq_scan_checker #(.CH_W(CH_W)) i_chk (
  .clk(clk), .rstN(rstN), .evtValid(evtValid), .evtReady(evtReady),
  .evtId(evtId), .minCh(minCh), .maxCh(maxCh),
  .regEn(regEn), .regCh(regCh), .clrEn(clrEn)
);

// File: tb/test_irq_scan_top.sv
module test_irq_scan_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 64;
  localparam int LINES  = 8;
  localparam int CH_W   = 8;
  localparam int PPID_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_CH*LINES-1:0] irqIn = '0;
  logic clrEn = 1'b0;
  logic [CH_W-1:0] clrCh = '0;
  logic [LINES-1:0] clrMask = '0;
  logic enCmdValid = 1'b0;
  logic [CH_W-1:0] enCmdCh = '0;
  logic enCmdOn = 1'b0;
  logic regEn = 1'b0;
  logic [CH_W-1:0] regCh = '0;
  logic [PPID_W-1:0] regPpid = '0;
  logic evtReady = 1'b0;
  logic evtValid;
  logic [31:0] evtId;
  logic [CH_W-1:0] minCh, maxCh;

  int errors = 0;
  int checks = 0;
  int hsCount = 0;
  logic [31:0] expQ[$];
  string curTag = "R4";

  irq_scan_top #(.NUM_CH(NUM_CH), .LINES(LINES), .CH_W(CH_W), .PPID_W(PPID_W)) i_irq_scan_top (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .clrEn(clrEn), .clrCh(clrCh),
    .clrMask(clrMask), .enCmdValid(enCmdValid), .enCmdCh(enCmdCh),
    .enCmdOn(enCmdOn), .regEn(regEn), .regCh(regCh), .regPpid(regPpid),
    .evtReady(evtReady), .evtValid(evtValid), .evtId(evtId),
    .minCh(minCh), .maxCh(maxCh)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // scoreboard monitor: one pop per handshake
  always @(negedge clk) begin
    if (rstN && evtValid && evtReady) begin
      logic [31:0] exp;
      hsCount++;
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected event act=%h exp=none", curTag, evtId);
      end else begin
        exp = expQ.pop_front();
        if (evtId !== exp) begin
          errors++;
          $display("FAIL %s: event act=%h exp=%h", curTag, evtId, exp);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pend(input int ch, input logic [LINES-1:0] bits);
    irqIn[ch*LINES +: LINES] = bits;
    waitCyc(1);
    irqIn = '0;
  endtask

  task automatic clearCh(input int ch, input logic [LINES-1:0] m);
    clrEn = 1'b1; clrCh = CH_W'(ch); clrMask = m;
    waitCyc(1);
    clrEn = 1'b0;
  endtask

  task automatic setEn(input int ch, input logic on);
    enCmdValid = 1'b1; enCmdCh = CH_W'(ch); enCmdOn = on;
    waitCyc(1);
    enCmdValid = 1'b0;
  endtask

  task automatic regChan(input int ch, input logic [PPID_W-1:0] id);
    regEn = 1'b1; regCh = CH_W'(ch); regPpid = id;
    waitCyc(1);
    regEn = 1'b0;
  endtask

  task automatic consume(input int k);
    int target;
    target = hsCount + k;
    evtReady = 1'b1;
    wait (hsCount >= target);
    @(posedge clk);
    #1 evtReady = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(1);
    // R1 reset state
    check("R1 valid", {31'd0, evtValid}, 32'd0);
    check("R1 minCh", {24'd0, minCh}, 32'd255);
    check("R1 maxCh", {24'd0, maxCh}, 32'd0);

    // R3 empty window: pending enabled channel but nothing registered
    setEn(3, 1'b1);
    pend(3, 8'h05);
    waitCyc(30);
    check("R3 empty window", {31'd0, evtValid}, 32'd0);

    // R2 bounds
    regChan(3, 12'h123);
    check("R2 min after ch3", {24'd0, minCh}, 32'd3);
    check("R2 max after ch3", {24'd0, maxCh}, 32'd3);
    regChan(40, 12'hABC);
    regChan(33, 12'h055);
    check("R2 min", {24'd0, minCh}, 32'd3);
    check("R2 max", {24'd0, maxCh}, 32'd40);

    // R4/R5 ordering and packing over two words
    setEn(33, 1'b1);
    setEn(40, 1'b1);
    pend(40, 8'h81);
    pend(33, 8'h10);
    waitCyc(10);
    curTag = "R4_R5 order";
    expQ.push_back(32'h0123_0003);
    expQ.push_back(32'h0123_0203);
    expQ.push_back(32'h0055_0421);
    expQ.push_back(32'h0ABC_0028);
    expQ.push_back(32'h0ABC_0728);
    consume(5);
    // R6 uncleared bits come back on the next pass
    waitCyc(20);
    check("R6 repass valid", {31'd0, evtValid}, 32'd1);
    check("R6 repass id", evtId, 32'h0123_0003);
    // R7 clear all
    clearCh(3, 8'hFF);
    clearCh(33, 8'hFF);
    clearCh(40, 8'hFF);
    waitCyc(20);
    check("R7 cleared idle", {31'd0, evtValid}, 32'd0);

    // R8 masked channel skipped
    setEn(33, 1'b0);
    pend(33, 8'h01);
    pend(3, 8'h02);
    waitCyc(20);
    curTag = "R8 masked skip";
    expQ.push_back(32'h0123_0103);
    consume(1);
    waitCyc(20);
    check("R6 second pass", evtId, 32'h0123_0103);
    clearCh(3, 8'h02);
    waitCyc(20);
    check("R8 masked pending silent", {31'd0, evtValid}, 32'd0);
    setEn(33, 1'b1);
    waitCyc(20);
    check("R8 unmask valid", {31'd0, evtValid}, 32'd1);
    check("R8 unmask id", evtId, 32'h0055_0021);
    curTag = "R8 unmask";
    expQ.push_back(32'h0055_0021);
    consume(1);
    clearCh(33, 8'hFF);
    waitCyc(20);
    check("R7 idle after clear", {31'd0, evtValid}, 32'd0);

    // R9 stall then R10 retraction
    pend(40, 8'h06);
    waitCyc(10);
    check("R9 stall id", evtId, 32'h0ABC_0128);
    waitCyc(30);
    check("R9 stall held", evtId, 32'h0ABC_0128);
    check("R9 stall valid", {31'd0, evtValid}, 32'd1);
    clearCh(40, 8'h02);
    waitCyc(20);
    check("R10 retract id", evtId, 32'h0ABC_0228);
    curTag = "R10 retract";
    expQ.push_back(32'h0ABC_0228);
    consume(1);
    clearCh(40, 8'hFF);
    waitCyc(20);
    check("R10 idle", {31'd0, evtValid}, 32'd0);

    // R7 set beats clear in the same cycle
    irqIn[3*LINES +: LINES] = 8'h20;
    clrEn = 1'b1; clrCh = 8'd3; clrMask = 8'h20;
    waitCyc(1);
    irqIn = '0; clrEn = 1'b0;
    waitCyc(20);
    check("R7 set wins id", evtId, 32'h0123_0503);
    curTag = "R7 set wins";
    expQ.push_back(32'h0123_0503);
    consume(1);
    clearCh(3, 8'hFF);
    waitCyc(20);
    check("R7 final idle", {31'd0, evtValid}, 32'd0);
    check("R4 scoreboard drained", expQ.size(), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule